// File: doc/BRIEF.md
# Oversampled Serial Receiver with Sticky Error Flags

This block receives asynchronous serial frames on a single input line and turns them into bytes. The frame has one start bit, DATA_W data bits sent least significant bit first, one parity bit and one stop bit. Each bit is sampled four times, once at the centre of each quarter of the bit period. A start bit is accepted only when all four of its samples read low, so short glitches on an idle line are ignored.

Each accepted frame goes into a receive shift register. Its data bits then pass through a one-byte hold stage into a receive FIFO. A read strobe pops the oldest byte onto a parallel output. Four sticky flags report problems: parity mismatch, framing faults, overrun and a line held low for too long. Framing faults are either a low stop bit or a bit whose four samples disagree. The flags stay set until they are cleared by a strobe.

The oversample divider, the data width, the parity sense and the FIFO depth are parameters. The defaults are 4 × 9600 samples per second from a 50 MHz clock, 8-bit data, even parity and a 16-byte FIFO.

Top module: `uart_err_rx`

## Requirements
- R1: A falling edge on the line starts a candidate start bit. The candidate is accepted only if all four of its quarter-bit samples read low. Otherwise it is dropped: no byte is stored and no flag changes.
- R2: A frame is a low start bit, DATA_W data bits sent LSB first, a parity bit and a high stop bit, each lasting 4 × CLK_DIV clocks. The samples fall CLK_DIV/2 + k·CLK_DIV clocks (k = 0..3) into each bit, counted from the detected edge. A bit reads as 1 when two or more of its four samples are high.
- R3: A pulse on rd_en while rx_empty is low makes rd_valid high on the next cycle, with the oldest stored byte on rd_data. Bytes come out in arrival order. A pulse on rd_en while rx_empty is high produces no rd_valid.
- R4: status bit 0 (parity) is set when the received parity bit differs from the XOR of the data bits, XORed with ODD_PARITY. With the default ODD_PARITY = 0 this is even parity.
- R5: status bit 1 (frame) is set when the stop bit reads low, or when the four samples of any bit in the frame are not all equal. The byte is still stored, using the vote value from R2.
- R6: The hold stage keeps one byte beyond the FIFO depth. A frame that completes while both the FIFO and the hold stage are full is discarded and sets status bit 2 (overrun). The bytes already stored are kept.
- R7: status bit 3 (break) is set once the line has been low for more than (DATA_W+3) × 4 × CLK_DIV consecutive clocks. A frame whose data bits are all zero does not set it.
- R8: Every status bit stays set until stat_clr is pulsed. The bits are zero on the cycle after the pulse unless a new event occurs in that same cycle.
- R9: After reset, status is zero, rx_empty is high and rd_valid is low.
- R10: Frames sent back to back, with the next start edge immediately after a stop bit, are all received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd | input | 1 | Serial input line, idle high |
| rd_en | input | 1 | Read strobe, pops one byte |
| stat_clr | input | 1 | Clears all status flags |
| rd_data | output | DATA_W | Byte popped by the last read |
| rd_valid | output | 1 | rd_data carries a popped byte this cycle |
| rx_empty | output | 1 | The FIFO holds no byte |
| status | output | 4 | Sticky flags: bit 0 parity, bit 1 frame, bit 2 overrun, bit 3 break |

## Verification
The bench builds the block with CLK_DIV = 4 and FIFO_DEPTH = 4. This gives a 16-clock bit, so a full frame takes a few hundred clocks. That makes it practical to sweep all 256 data bytes and to reach overrun after only six frames. Within these short bits the bench places glitches that hit exactly one or two of the four samples, which exercises the disagreement rule and the two-of-four vote. It also drives breaks measured against the 176-clock frame time.

// File: rtl/uart_err_rx_pkg.sv
package uart_err_rx_pkg;

  typedef enum logic [0:0] {
    RX_IDLE = 1'b0,
    RX_RUN  = 1'b1
  } rx_state_e;

  // status vector layout: [0] parity, [1] frame, [2] overrun, [3] break
  typedef struct packed {
    logic brk;
    logic ovr;
    logic frm;
    logic par;
  } rx_status_t;

  // two or more high samples out of four read as a one
  function automatic logic vote_value(input logic [3:0] s);
    logic [2:0] n;
    n = 3'(s[0]) + 3'(s[1]) + 3'(s[2]) + 3'(s[3]);
    return (n >= 3'd2);
  endfunction

  // samples of one bit are not unanimous
  function automatic logic vote_split(input logic [3:0] s);
    return !((&s) || (~|s));
  endfunction

endpackage

// File: rtl/uart_err_rx_sync.sv
module uart_err_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd,
  output logic line,
  output logic fall
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-1:0], rxd};
  end

  assign line = chain[STAGES-1];
  assign fall = chain[STAGES] & ~chain[STAGES-1];
endmodule

// File: rtl/uart_err_rx_framer.sv
module uart_err_rx_framer
  import uart_err_rx_pkg::*;
#(
  parameter int CLK_DIV    = 1302,
  parameter int DATA_W     = 8,
  parameter bit ODD_PARITY = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line,
  input  logic              fall,
  output logic              frame_done,
  output logic [DATA_W-1:0] frame_data,
  output logic              frame_par_err,
  output logic              frame_frm_err
);
  localparam int FRAME_BITS = DATA_W + 3;
  localparam int SHIFT_W    = DATA_W + 4;
  localparam int DIV_W      = $clog2(CLK_DIV);
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam logic [DIV_W-1:0] HALF_LD = DIV_W'(CLK_DIV / 2);
  localparam logic [DIV_W-1:0] FULL_LD = DIV_W'(CLK_DIV - 1);
  localparam logic [BIT_W-1:0] LAST_IX = BIT_W'(FRAME_BITS - 1);

  rx_state_e          state;
  logic [DIV_W-1:0]   div_cnt;
  logic [1:0]         qtr;
  logic [2:0]         samp;
  logic [BIT_W-1:0]   bit_idx;
  logic [SHIFT_W-1:0] shreg;

  logic               tick, bit_end, bval, bsplit;
  logic [3:0]         quad;
  logic [SHIFT_W-1:0] next_sh;

  assign tick    = (state == RX_RUN) && (div_cnt == '0);
  assign bit_end = tick && (qtr == 2'd3);
  assign quad    = {line, samp};
  assign bval    = vote_value(quad);
  assign bsplit  = vote_split(quad);
  // MSB accumulates sample disagreement; the lower bits shift right, LSB first
  assign next_sh = {shreg[SHIFT_W-1] | bsplit, bval, shreg[SHIFT_W-2:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= RX_IDLE;
      div_cnt       <= '0;
      qtr           <= '0;
      samp          <= '0;
      bit_idx       <= '0;
      shreg         <= '0;
      frame_done    <= 1'b0;
      frame_data    <= '0;
      frame_par_err <= 1'b0;
      frame_frm_err <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      unique case (state)
        RX_IDLE: begin
          if (fall) begin
            state   <= RX_RUN;
            div_cnt <= HALF_LD;
            qtr     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
          end
        end
        RX_RUN: begin
          if (tick) begin
            div_cnt <= FULL_LD;
            samp    <= {samp[1:0], line};
            qtr     <= qtr + 2'd1;
            if (bit_end) begin
              if (bit_idx == '0 && quad != 4'b0000) begin
                state <= RX_IDLE;
              end else begin
                shreg <= next_sh;
                if (bit_idx == LAST_IX) begin
                  state         <= RX_IDLE;
                  frame_done    <= 1'b1;
                  frame_data    <= next_sh[DATA_W:1];
                  frame_par_err <= (^next_sh[DATA_W+1:1]) ^ ODD_PARITY;
                  frame_frm_err <= next_sh[SHIFT_W-1] | ~next_sh[DATA_W+2]
                                 | next_sh[0];
                end else begin
                  bit_idx <= bit_idx + 1'b1;
                end
              end
            end
          end else begin
            div_cnt <= div_cnt - 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_err_rx_brk.sv
module uart_err_rx_brk #(
  parameter int LIMIT = 57288
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line,
  output logic brk_evt
);
  localparam int CNT_W = $clog2(LIMIT + 2);
  localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);
  localparam logic [CNT_W-1:0] SAT_V = CNT_W'(LIMIT + 1);

  logic [CNT_W-1:0] low_cnt;

  assign brk_evt = !line && (low_cnt == LIM_V);

  always_ff @(posedge clk) begin
    if (!rst_n)            low_cnt <= '0;
    else if (line)         low_cnt <= '0;
    else if (low_cnt != SAT_V) low_cnt <= low_cnt + 1'b1;
  end
endmodule

// File: rtl/uart_err_rx_fifo.sv
module uart_err_rx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [DATA_W-1:0]          push_data,
  input  logic                       pop,
  output logic [DATA_W-1:0]          head,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp, rp;

  assign head = mem[rp];
  assign full = (level == LW'(DEPTH));

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      if (push && !pop)      level <= level + 1'b1;
      else if (pop && !push) level <= level - 1'b1;
    end
  end
endmodule

// File: rtl/uart_err_rx.sv
module uart_err_rx
  import uart_err_rx_pkg::*;
#(
  parameter int CLK_DIV    = 1302,
  parameter int DATA_W     = 8,
  parameter bit ODD_PARITY = 1'b0,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic              rd_en,
  input  logic              stat_clr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rx_empty,
  output logic [3:0]        status
);
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1);
  localparam int BRK_LIMIT = (DATA_W + 3) * 4 * CLK_DIV;

  logic              line, fall;
  logic              frame_done, frame_par_err, frame_frm_err;
  logic [DATA_W-1:0] frame_data;
  logic              brk_evt, ovr_evt;
  logic              hold_full, xfer, load, pop;
  logic [DATA_W-1:0] hold_data, head;
  logic              fifo_full;
  logic [LVL_W-1:0]  fifo_level;
  rx_status_t        stat_q, stat_ev;

  uart_err_rx_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .line(line), .fall(fall)
  );

  uart_err_rx_framer #(
    .CLK_DIV(CLK_DIV), .DATA_W(DATA_W), .ODD_PARITY(ODD_PARITY)
  ) u_framer (
    .clk(clk), .rst_n(rst_n), .line(line), .fall(fall),
    .frame_done(frame_done), .frame_data(frame_data),
    .frame_par_err(frame_par_err), .frame_frm_err(frame_frm_err)
  );

  uart_err_rx_brk #(.LIMIT(BRK_LIMIT)) u_brk (
    .clk(clk), .rst_n(rst_n), .line(line), .brk_evt(brk_evt)
  );

  uart_err_rx_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(xfer), .push_data(hold_data),
    .pop(pop), .head(head), .full(fifo_full), .level(fifo_level)
  );

  // hold stage: one byte parked while the FIFO has no room
  assign xfer    = hold_full && !fifo_full;
  assign load    = frame_done && (!hold_full || xfer);
  assign ovr_evt = frame_done && hold_full && fifo_full;
  assign pop     = rd_en && !rx_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else begin
      if (xfer) hold_full <= 1'b0;
      if (load) begin
        hold_full <= 1'b1;
        hold_data <= frame_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= pop;
      if (pop) rd_data <= head;
    end
  end

  always_comb begin
    stat_ev.par = frame_done && frame_par_err;
    stat_ev.frm = frame_done && frame_frm_err;
    stat_ev.ovr = ovr_evt;
    stat_ev.brk = brk_evt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~{4{stat_clr}}) | stat_ev;
  end

  assign status   = stat_q;
  assign rx_empty = (fifo_level == '0);
endmodule

// File: rtl/uart_err_rx_chk.sv
module uart_err_rx_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rd_en,
  input logic                       stat_clr,
  input logic                       rd_valid,
  input logic                       rx_empty,
  input logic [3:0]                 status,
  input logic                       frame_done,
  input logic                       ovr_evt,
  input logic                       brk_evt,
  input logic                       line,
  input logic [$clog2(DEPTH+1)-1:0] fifo_level
);
  a_r3_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en));

  a_r3_no_valid_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rx_empty) |=> !rd_valid);

  a_r6_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= ($clog2(DEPTH+1))'(DEPTH));

  a_r6_overrun_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |-> !rx_empty);

  a_r7_break_line_low: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |-> !line);

  a_r2_done_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_clr |=> ((status & $past(status)) == $past(status)));

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !frame_done && !ovr_evt && !brk_evt) |=> (status == 4'b0000));
endmodule

bind uart_err_rx uart_err_rx_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .stat_clr(stat_clr),
  .rd_valid(rd_valid), .rx_empty(rx_empty), .status(status),
  .frame_done(frame_done), .ovr_evt(ovr_evt), .brk_evt(brk_evt),
  .line(line), .fifo_level(fifo_level)
);

// File: tb/uart_err_rx_bench.sv
module uart_err_rx_bench;
  localparam int DIV   = 4;
  localparam int DEPTH = 4;
  localparam int BIT   = 4 * DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       rd_en = 1'b0;
  logic       stat_clr = 1'b0;
  logic [7:0] rd_data;
  logic       rd_valid, rx_empty;
  logic [3:0] status;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  uart_err_rx #(.CLK_DIV(DIV), .DATA_W(8), .ODD_PARITY(1'b0), .FIFO_DEPTH(DEPTH))
    u_uart_err_rx (
      .clk(clk), .rst_n(rst_n), .rxd(rxd), .rd_en(rd_en), .stat_clr(stat_clr),
      .rd_data(rd_data), .rd_valid(rd_valid), .rx_empty(rx_empty), .status(status)
    );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rxd = 1'b1;
    end
  endtask

  // glitch flips the line for glen clocks starting 4 clocks into bit gbit
  task automatic send_frame(input logic [7:0] d, input logic par_flip,
                            input logic stop_v, input int gbit, input int glen);
    logic [10:0] bits;
    bits = {stop_v, (^d) ^ par_flip, d, 1'b0};
    for (int b = 0; b < 11; b++) begin
      for (int c = 0; c < BIT; c++) begin
        @(negedge clk);
        rxd = (b == gbit && c >= 4 && c < 4 + glen) ? ~bits[b] : bits[b];
      end
    end
  endtask

  task automatic read_byte(input string req, input logic [7:0] exp);
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, {31'b0, rd_valid}, 32'd1);
    chk(req, {24'b0, rd_data}, {24'b0, exp});
    idle(3);
  endtask

  task automatic clear_status;
    @(negedge clk);
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
    chk("R8 clear", {28'b0, status}, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (6) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 status", {28'b0, status}, 32'h0);
    chk("R9 empty", {31'b0, rx_empty}, 32'd1);
    chk("R9 valid", {31'b0, rd_valid}, 32'd0);

    // R3 read while empty yields nothing
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    chk("R3 empty read", {31'b0, rd_valid}, 32'd0);

    // R2 sweep over every byte value, R7 all-zero frame never breaks
    for (int v = 0; v < 256; v++) begin
      send_frame(8'(v), 1'b0, 1'b1, -1, 0);
      idle(10);
      chk("R2 clean status", {28'b0, status}, 32'h0);
      read_byte("R2 sweep data", 8'(v));
    end

    // R10 back-to-back frames
    send_frame(8'hA5, 1'b0, 1'b1, -1, 0);
    send_frame(8'h5A, 1'b0, 1'b1, -1, 0);
    send_frame(8'h0F, 1'b0, 1'b1, -1, 0);
    send_frame(8'hF0, 1'b0, 1'b1, -1, 0);
    idle(10);
    chk("R10 status", {28'b0, status}, 32'h0);
    read_byte("R10 b0", 8'hA5);
    read_byte("R10 b1", 8'h5A);
    read_byte("R10 b2", 8'h0F);
    read_byte("R10 b3", 8'hF0);
    chk("R10 drained", {31'b0, rx_empty}, 32'd1);

    // R1 false starts: one low sample, then three low samples
    @(negedge clk); rxd = 1'b0;
    repeat (3) @(negedge clk);
    idle(200);
    chk("R1 short glitch empty", {31'b0, rx_empty}, 32'd1);
    chk("R1 short glitch status", {28'b0, status}, 32'h0);
    @(negedge clk); rxd = 1'b0;
    repeat (11) @(negedge clk);
    idle(200);
    chk("R1 three-sample empty", {31'b0, rx_empty}, 32'd1);
    chk("R1 three-sample status", {28'b0, status}, 32'h0);

    // R4 parity error, then R8 stickiness across a clean frame
    send_frame(8'h3C, 1'b1, 1'b1, -1, 0);
    idle(10);
    chk("R4 parity flag", {28'b0, status}, 32'h1);
    read_byte("R4 data kept", 8'h3C);
    send_frame(8'h11, 1'b0, 1'b1, -1, 0);
    idle(10);
    chk("R8 sticky parity", {28'b0, status}, 32'h1);
    read_byte("R8 data", 8'h11);
    clear_status();

    // R5 low stop bit
    send_frame(8'h77, 1'b0, 1'b0, -1, 0);
    idle(10);
    chk("R5 stop low", {28'b0, status}, 32'h2);
    read_byte("R5 stop low data", 8'h77);
    clear_status();

    // R5 single-sample disagreement on a zero data bit and on a one data bit
    send_frame(8'h00, 1'b0, 1'b1, 4, 4);
    idle(10);
    chk("R5 split zero", {28'b0, status}, 32'h2);
    read_byte("R5 split zero data", 8'h00);
    clear_status();
    send_frame(8'hFF, 1'b0, 1'b1, 2, 4);
    idle(10);
    chk("R5 split one", {28'b0, status}, 32'h2);
    read_byte("R5 split one data", 8'hFF);
    clear_status();

    // R2 two-of-four tie reads as one: data bit0 flips, so parity fails too
    send_frame(8'h00, 1'b0, 1'b1, 1, 8);
    idle(10);
    chk("R2 tie status", {28'b0, status}, 32'h3);
    read_byte("R2 tie data", 8'h01);
    clear_status();

    // R7 break: line low well past one frame time
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      rxd = 1'b0;
    end
    idle(20);
    chk("R7 break status", {28'b0, status}, 32'hA);
    read_byte("R7 break data", 8'h00);
    clear_status();

    // R6 overrun: four in FIFO, fifth in hold, sixth dropped
    for (int i = 0; i < 6; i++) begin
      send_frame(8'h10 + 8'(i), 1'b0, 1'b1, -1, 0);
      idle(10);
      if (i == 4) chk("R6 no overrun yet", {28'b0, status}, 32'h0);
    end
    chk("R6 overrun flag", {28'b0, status}, 32'h4);
    for (int i = 0; i < 5; i++) read_byte("R6 kept order", 8'h10 + 8'(i));
    chk("R6 sixth dropped", {31'b0, rx_empty}, 32'd1);
    clear_status();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule